// File: doc/BRIEF.md
# PWM Duty Offset Correction Stage

This stage sits directly in front of a six-channel PWM comparator. Each duty-cycle word arrives with its channel index and a valid strobe. The stage adds a signed, per-channel correction to that word so that DC offset in the external power stage is cancelled. The corrected word is clamped to the legal duty range and leaves the stage one clock later, still tagged with its channel.

Software programs one 8-bit correction code per channel through a plain register-write port (address, data, strobe), and may do so at any time. Written codes first land in a staging bank. A small commit controller then copies the staging bank into the live bank only on a PWM frame tick, so a change never lands in the middle of a period. The controller has two states, named below. Each code covers 256 steps. The full set of steps spans 1.5625% of the 16-bit duty scale, split evenly around zero.

Commit controller states and transitions:
- `ST_IDLE` means the live bank equals the staging bank. A write to a valid channel address moves it to `ST_ARMED`.
- `ST_ARMED` means the staging bank holds changes that have not yet taken effect. A frame tick copies staging into live. After that tick the controller returns to `ST_IDLE`, unless a valid write arrives in that same cycle, in which case it stays in `ST_ARMED`.

Top module: `pwmofs_top`

## Requirements
- R1: After reset every live and staged code is 00h, so each duty word passes through unchanged, and `out_valid` is low.
- R2: Channels 0 to 5 each have their own code, selected by `wr_addr`. A code written to one channel changes no other channel.
- R3: The code is two's complement (-128 to +127). The output equals the input duty plus the code times 4, for both positive and negative codes.
- R4: When the sum exceeds 65535, the output is exactly 65535. The sum never wraps to a low value.
- R5: When the sum is below 0, the output is exactly 0. The sum never wraps to a high value.
- R6: A written code takes effect only at the next `frame_tick` pulse. A sample presented in the same cycle as that tick still uses the previous code. A write in the same cycle as a tick takes effect at the following tick.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_chan` and `out_duty` belong to the sample presented one clock earlier. `out_valid` is low in any cycle that follows a cycle with no input.
- R8: Writes to addresses 6 and 7 are ignored and change no channel's correction.
- R9: A sample with `in_chan` of 6 or 7 passes through with its duty word unchanged.
- R10: If a channel is written several times before a tick, only the last value written is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Channel whose code is written |
| wr_data | input | 8 | Two's complement correction code |
| frame_tick | input | 1 | One-cycle pulse at each PWM frame boundary |
| in_valid | input | 1 | Input duty word is valid |
| in_chan | input | 3 | Channel of the input duty word |
| in_duty | input | 16 | Uncorrected duty word |
| out_valid | output | 1 | Corrected word is valid |
| out_chan | output | 3 | Channel of the corrected word |
| out_duty | output | 16 | Corrected and clamped duty word |

## Verification
The correction path is driven with a different code on every channel: small positive and negative values and both code extremes. A swap of channel selection or a sign-handling error therefore shows up as a wrong value on a specific channel. Duty words are placed exactly at the clamp thresholds and just beyond them, which separates correct saturation from wraparound and from off-by-one clamping. Timing patterns check three cases: a sample before a commit, a sample in the same cycle as the tick, and a sample after the tick. Together these locate the exact cycle in which a new code takes effect. Writes to unused addresses, samples on unused channel numbers, and repeated writes before a tick check the boundaries of the register bank.

// File: rtl/pwmofs_pkg.sv
package pwmofs_pkg;
    // State of the commit controller: either live and staged banks agree, or
    // staged changes are waiting for the next frame tick.
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } commit_st_e;
endpackage

// File: rtl/pwmofs_regbank.sv
module pwmofs_regbank
    import pwmofs_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int OFS_W = 8,
    parameter int CH_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CH_W-1:0]            wr_addr,
    input  logic [OFS_W-1:0]           wr_data,
    input  logic                       frame_tick,
    output logic [NCH-1:0][OFS_W-1:0]  act_ofs
);
    logic [NCH-1:0][OFS_W-1:0] stg_ofs;
    commit_st_e                state_q;
    commit_st_e                state_d;
    logic                      wr_hit;
    logic                      commit_en;

    // A write counts only when it targets an existing channel.
    assign wr_hit = wr_en && (int'(wr_addr) < NCH);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_hit) state_d = ST_ARMED;
            ST_ARMED: if (frame_tick && !wr_hit) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode: copy staged into live only on a tick while armed.
    always_comb begin
        commit_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  commit_en = 1'b0;
            ST_ARMED: commit_en = frame_tick;
            default:  commit_en = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg_ofs[g] <= '0;
            else if (wr_en && (wr_addr == CH_W'(g)))
                stg_ofs[g] <= wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                act_ofs[g] <= '0;
            else if (commit_en)
                act_ofs[g] <= stg_ofs[g];
        end
    end
endmodule

// File: rtl/pwmofs_sat.sv
module pwmofs_sat #(
    parameter int DUTY_W    = 16,
    parameter int OFS_W     = 8,
    parameter int OFS_SHIFT = 2
) (
    input  logic [DUTY_W-1:0] duty,
    input  logic [OFS_W-1:0]  code,
    output logic [DUTY_W-1:0] result
);
    // Wide enough for any duty plus any scaled code, with a sign bit to spare.
    localparam int SUM_W = DUTY_W + OFS_W + OFS_SHIFT;
    localparam logic signed [SUM_W-1:0] MAX_V =
        {{(SUM_W-DUTY_W){1'b0}}, {DUTY_W{1'b1}}};

    logic signed [SUM_W-1:0] code_ext;
    logic signed [SUM_W-1:0] corr;
    logic signed [SUM_W-1:0] duty_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        code_ext = SUM_W'(signed'(code));
        corr     = code_ext <<< OFS_SHIFT;
        duty_ext = signed'({{(SUM_W-DUTY_W){1'b0}}, duty});
        sum      = duty_ext + corr;
        if (sum < 0)
            result = '0;
        else if (sum > MAX_V)
            result = '1;
        else
            result = sum[DUTY_W-1:0];
    end
endmodule

// File: rtl/pwmofs_top.sv
module pwmofs_top #(
    parameter int NCH       = 6,
    parameter int DUTY_W    = 16,
    parameter int OFS_W     = 8,
    parameter int OFS_SHIFT = 2,
    localparam int CH_W     = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_addr,
    input  logic [OFS_W-1:0]  wr_data,
    input  logic              frame_tick,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [DUTY_W-1:0] in_duty,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic [DUTY_W-1:0] out_duty
);
    logic [NCH-1:0][OFS_W-1:0] act_ofs;
    logic [OFS_W-1:0]          sel_code;
    logic [DUTY_W-1:0]         sat_res;

    pwmofs_regbank #(.NCH(NCH), .OFS_W(OFS_W), .CH_W(CH_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_tick (frame_tick),
        .act_ofs    (act_ofs)
    );

    // Unused channel numbers select a zero code.
    always_comb begin
        sel_code = '0;
        for (int i = 0; i < NCH; i++) begin
            if (in_chan == CH_W'(i)) sel_code = act_ofs[i];
        end
    end

    pwmofs_sat #(.DUTY_W(DUTY_W), .OFS_W(OFS_W), .OFS_SHIFT(OFS_SHIFT)) u_sat (
        .duty   (in_duty),
        .code   (sel_code),
        .result (sat_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_duty  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan <= in_chan;
                out_duty <= sat_res;
            end
        end
    end
endmodule

// File: rtl/pwmofs_chk.sv
module pwmofs_chk #(
    parameter int NCH    = 6,
    parameter int DUTY_W = 16,
    parameter int OFS_W  = 8,
    parameter int CH_W   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_tick,
    input logic                      in_valid,
    input logic [CH_W-1:0]           in_chan,
    input logic [DUTY_W-1:0]         in_duty,
    input logic                      out_valid,
    input logic [CH_W-1:0]           out_chan,
    input logic [DUTY_W-1:0]         out_duty,
    input logic [NCH-1:0][OFS_W-1:0] act_ofs
);
    // R7
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    a_r7_chan_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_chan == $past(in_chan)));
    // R6: the live bank moves only on a frame tick
    a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(act_ofs));
    // R9
    a_r9_unused_chan_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (int'(in_chan) >= NCH)) |=> (out_duty == $past(in_duty)));
    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_ofs == '0));
endmodule

bind pwmofs_top pwmofs_chk #(
    .NCH(NCH), .DUTY_W(DUTY_W), .OFS_W(OFS_W), .CH_W(CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_duty    (in_duty),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_duty   (out_duty),
    .act_ofs    (act_ofs)
);

// File: tb/sim_pwmofs_top.sv
module sim_pwmofs_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        frame_tick = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_chan = '0;
    logic [15:0] in_duty = '0;
    logic        out_valid;
    logic [2:0]  out_chan;
    logic [15:0] out_duty;

    int n_checks = 0;
    int n_fail = 0;
    int live_code [6];
    int stg_code  [6];

    always #4 clk = ~clk;

    pwmofs_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_tick(frame_tick), .in_valid(in_valid),
        .in_chan(in_chan), .in_duty(in_duty), .out_valid(out_valid),
        .out_chan(out_chan), .out_duty(out_duty)
    );

    function automatic int model(int chan, int duty);
        int v;
        v = duty;
        if (chan < 6) v = duty + live_code[chan] * 4;
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(int addr, int code);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(code);
        @(negedge clk);
        wr_en = 1'b0;
        if (addr < 6) stg_code[addr] = code;
    endtask

    task automatic tick();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        for (int i = 0; i < 6; i++) live_code[i] = stg_code[i];
    endtask

    task automatic sample(string req, int ch, int duty, int exp);
        @(negedge clk);
        in_valid = 1'b1; in_chan = 3'(ch); in_duty = 16'(duty);
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, int'(out_valid), 1);
        chk(req, int'(out_chan), ch);
        chk(req, int'(out_duty), exp);
    endtask

    task automatic t_reset();
        chk("R1", int'(out_valid), 0);
        for (int c = 0; c < 6; c++) sample("R1", c, 1000 + c, 1000 + c);
    endtask

    task automatic t_program_and_commit();
        int codes [6] = '{1, -1, 127, -128, 50, -7};
        for (int c = 0; c < 6; c++) write_reg(c, codes[c]);
        for (int c = 0; c < 6; c++) sample("R6", c, 20000, 20000);
        tick();
        for (int c = 0; c < 6; c++) sample("R2", c, 20000, model(c, 20000));
        sample("R3", 2, 20000, 20508);
        sample("R3", 3, 20000, 19488);
    endtask

    task automatic t_saturation();
        sample("R4", 2, 65535 - 508, 65535);
        sample("R4", 2, 65535 - 100, 65535);
        sample("R4", 2, 65535 - 509, 65534);
        sample("R5", 3, 512, 0);
        sample("R5", 3, 300, 0);
        sample("R5", 3, 513, 1);
    endtask

    task automatic t_same_cycle_tick();
        write_reg(0, 10);
        @(negedge clk);
        frame_tick = 1'b1; in_valid = 1'b1; in_chan = 3'd0; in_duty = 16'd4000;
        @(negedge clk);
        frame_tick = 1'b0; in_valid = 1'b0;
        chk("R6", int'(out_duty), 4004);
        for (int i = 0; i < 6; i++) live_code[i] = stg_code[i];
        sample("R6", 0, 4000, 4040);
    endtask

    task automatic t_write_with_tick();
        @(negedge clk);
        frame_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'd20;
        @(negedge clk);
        frame_tick = 1'b0; wr_en = 1'b0;
        sample("R6", 4, 1000, 1200);
        stg_code[4] = 20;
        tick();
        sample("R6", 4, 1000, 1080);
    endtask

    task automatic t_bad_addr();
        write_reg(6, 8'h55);
        write_reg(7, 8'h7f);
        tick();
        for (int c = 0; c < 6; c++) sample("R8", c, 30000, model(c, 30000));
    endtask

    task automatic t_bad_chan();
        sample("R9", 6, 1234, 1234);
        sample("R9", 7, 65535, 65535);
    endtask

    task automatic t_last_write();
        write_reg(1, 5);
        write_reg(1, 9);
        tick();
        sample("R10", 1, 100, 136);
    endtask

    task automatic t_latency();
        sample("R7", 5, 777, model(5, 777));
        @(negedge clk);
        chk("R7", int'(out_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin live_code[i] = 0; stg_code[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program_and_commit();
        t_saturation();
        t_same_cycle_tick();
        t_write_with_tick();
        t_bad_addr();
        t_bad_chan();
        t_last_write();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule